// File: doc/BRIEF.md
# Hash engine control register file

This block is the software-facing front end of a hash accelerator. A host reaches it through a simple 32-bit register bus with separate write and read strobes and a byte address. It stores the source, destination and key buffer addresses, the source byte count, a crypt command word and the hash command word. Each one is masked as it is written, and each stored address or length drives the datapath directly.

A write to the hash command register is decoded at once into an algorithm code and mode flags. When the algorithm selection is legal and no operation is in flight, the block issues a one-cycle start pulse and holds the decoded values steady for the datapath. The datapath reports completion with a single done pulse. That pulse sets a sticky done bit in the status register and, when the starting command asked for it, raises the interrupt line. Software clears both by writing 1 to the done bit.

Top module: `hash_csr`

## Requirements
- R1: After reset every register reads as zero, and `start_o`, `busy_o` and `irq_o` are low.
- R2: Writes are masked before they are stored. The crypt command word (offset 0x10) keeps all 32 bits. The source address (0x20) keeps bits [30:0]. The destination (0x24) and key buffer (0x28) keep bits [30:3]. The source length (0x2C) keeps bits [27:0]. The stored address and length values appear on their output ports.
- R3: A legal command selects the algorithm from the primary field [6:4] together with the sub-field [12:10]. The legal pairs are 000/000 = MD5 (code 0), 010/000 = SHA-1 (code 1), 100/000 = SHA-224 (code 2), 101/000 = SHA-256 (code 3), 110/000 = SHA-512 (code 5), 110/001 = SHA-384 (code 4) and 110/010 = SHA-256 (code 3). The code is driven on `alg_o`.
- R4: Any other pairing of the two fields produces no start pulse, although the command word is still stored.
- R5: The start pulse lasts exactly one cycle and comes in the cycle after the command write. With it, `sg_o` copies command bit 18, and `acc_o` is 1 only when bits [8:7] equal 10.
- R6: The hash command register (0x30) keeps only the bits set in 0x00147FFF.
- R7: A start raises `busy_o`. While `busy_o` is high no command produces a start pulse. A done pulse clears `busy_o`.
- R8: A done pulse while busy sets status bit 9 (offset 0x1C) whatever the interrupt enable was. `irq_o` goes high only if command bit 9 was set in the command that started the operation.
- R9: Writing a word with bit 9 set to the status register clears status bit 9 and lowers `irq_o`. Writing 0 there changes nothing.
- R10: An address that maps to no register reads as zero, and a write to it changes no register.
- R11: A done pulse while not busy is ignored: status bit 9 and `irq_o` stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| done_i | input | 1 | One-cycle completion pulse from the datapath |
| start_o | output | 1 | One-cycle operation start |
| alg_o | output | 3 | Decoded algorithm code |
| sg_o | output | 1 | Scatter-gather enable for the operation |
| acc_o | output | 1 | Accumulate mode for the operation |
| busy_o | output | 1 | Operation in flight |
| irq_o | output | 1 | Completion interrupt |
| src_addr_o | output | 32 | Masked source address |
| dst_addr_o | output | 32 | Masked destination address |
| key_addr_o | output | 32 | Masked key buffer address |
| src_len_o | output | 32 | Masked source length |

## Verification
The properties assume that `done_i` is a single-cycle pulse and that it arrives only after a start the datapath has accepted. They also assume that writes and reads never occur in the same cycle. The stimulus drives every strobe for exactly one cycle, leaves idle cycles between bus accesses, and raises done only as an isolated pulse. The one exception is the done pulse sent on purpose while the block is idle, which the properties treat as a no-op.

// File: rtl/hash_csr_pkg.sv
package hash_csr_pkg;

  typedef enum logic [2:0] {
    ALG_MD5    = 3'd0,
    ALG_SHA1   = 3'd1,
    ALG_SHA224 = 3'd2,
    ALG_SHA256 = 3'd3,
    ALG_SHA384 = 3'd4,
    ALG_SHA512 = 3'd5
  } hash_alg_e;

  localparam int NUM_STORE = 6;
  localparam int IDX_CRYPT = 0;
  localparam int IDX_SRC   = 1;
  localparam int IDX_DST   = 2;
  localparam int IDX_KEY   = 3;
  localparam int IDX_LEN   = 4;
  localparam int IDX_CMD   = 5;

  localparam logic [11:0] OFF_STATUS = 12'h01C;
  localparam logic [11:0] OFF_CMD    = 12'h030;

  localparam logic [11:0] STORE_OFF [NUM_STORE] = '{
    12'h010, 12'h020, 12'h024, 12'h028, 12'h02C, 12'h030
  };
  localparam logic [31:0] STORE_MASK [NUM_STORE] = '{
    32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFF8,
    32'h7FFF_FFF8, 32'h0FFF_FFFF, 32'h0014_7FFF
  };

  localparam int DONE_BIT = 9;
  localparam int IEN_BIT  = 9;
  localparam int SG_BIT   = 18;
  localparam logic [1:0] MODE_ACCUM = 2'b10;

endpackage

// File: rtl/hash_cmd_decode.sv
module hash_cmd_decode
  import hash_csr_pkg::*;
(
  input  logic [2:0] prim_f,
  input  logic [2:0] sub_f,
  input  logic [1:0] mode_f,
  output logic       valid,
  output hash_alg_e  alg,
  output logic       acc
);

  always_comb begin
    valid = 1'b0;
    alg   = ALG_MD5;
    case (prim_f)
      3'b000: begin valid = (sub_f == 3'b000); alg = ALG_MD5;    end
      3'b010: begin valid = (sub_f == 3'b000); alg = ALG_SHA1;   end
      3'b100: begin valid = (sub_f == 3'b000); alg = ALG_SHA224; end
      3'b101: begin valid = (sub_f == 3'b000); alg = ALG_SHA256; end
      3'b110: begin
        case (sub_f)
          3'b000:  begin valid = 1'b1; alg = ALG_SHA512; end
          3'b001:  begin valid = 1'b1; alg = ALG_SHA384; end
          3'b010:  begin valid = 1'b1; alg = ALG_SHA256; end
          default: begin valid = 1'b0; alg = ALG_MD5;    end
        endcase
      end
      default: begin valid = 1'b0; alg = ALG_MD5; end
    endcase
  end

  assign acc = (mode_f == MODE_ACCUM);

endmodule

// File: rtl/hash_csr_regs.sv
module hash_csr_regs
  import hash_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  input  logic                             stat_done,
  output logic [DATA_W-1:0]                rdata,
  output logic [NUM_STORE-1:0][DATA_W-1:0] store_o
);

  logic [NUM_STORE-1:0][DATA_W-1:0] store_q;
  logic [DATA_W-1:0]                rd_mux;

  for (genvar i = 0; i < NUM_STORE; i++) begin : g_store
    always_ff @(posedge clk) begin
      if (rst) begin
        store_q[i] <= '0;
      end else if (wr_en && addr == ADDR_W'(STORE_OFF[i])) begin
        store_q[i] <= wdata & DATA_W'(STORE_MASK[i]);
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_STORE; i++) begin
      if (addr == ADDR_W'(STORE_OFF[i])) rd_mux = store_q[i];
    end
    if (addr == ADDR_W'(OFF_STATUS)) rd_mux[DONE_BIT] = stat_done;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  assign store_o = store_q;

endmodule

// File: rtl/hash_csr_ctrl.sv
module hash_csr_ctrl
  import hash_csr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd_wr,
  input  logic      cmd_valid,
  input  hash_alg_e cmd_alg,
  input  logic      cmd_sg,
  input  logic      cmd_acc,
  input  logic      cmd_ien,
  input  logic      stat_wr,
  input  logic      stat_clr,
  input  logic      done_i,
  output logic      start_o,
  output logic [2:0] alg_o,
  output logic      sg_o,
  output logic      acc_o,
  output logic      busy_o,
  output logic      stat_done_o,
  output logic      irq_o
);

  logic go;
  logic fin;
  logic clr;
  logic ien_q;

  assign go  = cmd_wr && cmd_valid && !busy_o;
  assign fin = done_i && busy_o;
  assign clr = stat_wr && stat_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o     <= 1'b0;
      alg_o       <= '0;
      sg_o        <= 1'b0;
      acc_o       <= 1'b0;
      ien_q       <= 1'b0;
      busy_o      <= 1'b0;
      stat_done_o <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      start_o <= go;
      if (go) begin
        alg_o <= cmd_alg;
        sg_o  <= cmd_sg;
        acc_o <= cmd_acc;
        ien_q <= cmd_ien;
      end
      if (go)       busy_o <= 1'b1;
      else if (fin) busy_o <= 1'b0;
      // completion wins over a simultaneous clear
      if (fin)      stat_done_o <= 1'b1;
      else if (clr) stat_done_o <= 1'b0;
      if (fin && ien_q) irq_o <= 1'b1;
      else if (clr)     irq_o <= 1'b0;
    end
  end

endmodule

// File: rtl/hash_csr.sv
module hash_csr
  import hash_csr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              done_i,
  output logic              start_o,
  output logic [2:0]        alg_o,
  output logic              sg_o,
  output logic              acc_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic [31:0]       src_addr_o,
  output logic [31:0]       dst_addr_o,
  output logic [31:0]       key_addr_o,
  output logic [31:0]       src_len_o
);

  logic [NUM_STORE-1:0][31:0] store;
  logic      stat_done;
  logic      dec_valid;
  hash_alg_e dec_alg;
  logic      dec_acc;
  logic      cmd_wr;
  logic      stat_wr;

  assign cmd_wr  = wr_en && addr == ADDR_W'(OFF_CMD);
  assign stat_wr = wr_en && addr == ADDR_W'(OFF_STATUS);

  hash_csr_regs #(.ADDR_W(ADDR_W), .DATA_W(32)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .stat_done (stat_done),
    .rdata     (rdata),
    .store_o   (store)
  );

  hash_cmd_decode u_dec (
    .prim_f (wdata[6:4]),
    .sub_f  (wdata[12:10]),
    .mode_f (wdata[8:7]),
    .valid  (dec_valid),
    .alg    (dec_alg),
    .acc    (dec_acc)
  );

  hash_csr_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr      (cmd_wr),
    .cmd_valid   (dec_valid),
    .cmd_alg     (dec_alg),
    .cmd_sg      (wdata[SG_BIT]),
    .cmd_acc     (dec_acc),
    .cmd_ien     (wdata[IEN_BIT]),
    .stat_wr     (stat_wr),
    .stat_clr    (wdata[DONE_BIT]),
    .done_i      (done_i),
    .start_o     (start_o),
    .alg_o       (alg_o),
    .sg_o        (sg_o),
    .acc_o       (acc_o),
    .busy_o      (busy_o),
    .stat_done_o (stat_done),
    .irq_o       (irq_o)
  );

  assign src_addr_o = store[IDX_SRC];
  assign dst_addr_o = store[IDX_DST];
  assign key_addr_o = store[IDX_KEY];
  assign src_len_o  = store[IDX_LEN];

endmodule

// File: rtl/hash_csr_chk.sv
module hash_csr_chk (
  input logic clk,
  input logic rst,
  input logic start_o,
  input logic busy_o,
  input logic done_i,
  input logic irq_o,
  input logic stat_done
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!start_o && !irq_o && !busy_o));

  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> busy_o);

  // R7
  busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> !start_o);

  // R8
  done_status_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && busy_o) |=> stat_done);

  // R8
  irq_status_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> stat_done);

  // R11
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    (done_i && !busy_o && !stat_done) |=> !stat_done);

endmodule

bind hash_csr hash_csr_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_o   (start_o),
  .busy_o    (busy_o),
  .done_i    (done_i),
  .irq_o     (irq_o),
  .stat_done (stat_done)
);

// File: tb/hash_csr_tb.sv
module hash_csr_tb;

  localparam int ADDR_W = 12;
  localparam int WDOG   = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic done_i = 1'b0;
  logic start_o, sg_o, acc_o, busy_o, irq_o;
  logic [2:0] alg_o;
  logic [31:0] src_addr_o, dst_addr_o, key_addr_o, src_len_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic rd_seen = 1'b0;

  logic [31:0] rd_q[$];
  string       rd_tag_q[$];
  logic [4:0]  st_q[$];
  string       st_tag_q[$];

  always #10 clk = ~clk;

  hash_csr #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .done_i(done_i), .start_o(start_o),
    .alg_o(alg_o), .sg_o(sg_o), .acc_o(acc_o), .busy_o(busy_o),
    .irq_o(irq_o), .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o),
    .key_addr_o(key_addr_o), .src_len_o(src_len_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  // monitor: compares results against the scoreboard queues
  always @(negedge clk) begin
    if (rd_seen) begin
      if (rd_q.size() == 0) chk("read with no expectation", 32'h1, 32'h0);
      else chk(rd_tag_q.pop_front(), rdata, rd_q.pop_front());
    end
    if (start_o) begin
      if (st_q.size() == 0) chk("R4 R7 unexpected start", 32'h1, 32'h0);
      else chk(st_tag_q.pop_front(), {27'b0, alg_o, sg_o, acc_o}, {27'b0, st_q.pop_front()});
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    rd_q.push_back(exp);
    rd_tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
  endtask

  // command expected to start, then completed and cleared
  task automatic run_ok(logic [31:0] cmd, logic [2:0] alg, logic sg, logic acc, string tag);
    st_q.push_back({alg, sg, acc});
    st_tag_q.push_back(tag);
    wr(12'h030, cmd);
    chk({tag, " busy"}, {31'b0, busy_o}, 32'h1);
    pulse_done();
    chk({tag, " idle after done"}, {31'b0, busy_o}, 32'h0);
    wr(12'h01C, 32'h200);
  endtask

  task automatic run_bad(logic [31:0] cmd, string tag);
    wr(12'h030, cmd);
    chk({tag, " no busy"}, {31'b0, busy_o}, 32'h0);
    rd(12'h030, cmd & 32'h0014_7FFF, {tag, " stored"});
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1 start", {31'b0, start_o}, 32'h0);
    chk("R1 busy", {31'b0, busy_o}, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 src port", src_addr_o, 32'h0);
    rd(12'h010, 32'h0, "R1 crypt");
    rd(12'h01C, 32'h0, "R1 status");
    rd(12'h020, 32'h0, "R1 src");
    rd(12'h02C, 32'h0, "R1 len");
    rd(12'h030, 32'h0, "R1 cmd");

    // R2
    wr(12'h010, 32'hA5A5_5A5A);
    rd(12'h010, 32'hA5A5_5A5A, "R2 crypt");
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h024, 32'hFFFF_FFFF);
    wr(12'h028, 32'hFFFF_FFFF);
    wr(12'h02C, 32'hFFFF_FFFF);
    rd(12'h020, 32'h7FFF_FFFF, "R2 src");
    rd(12'h024, 32'h7FFF_FFF8, "R2 dst");
    rd(12'h028, 32'h7FFF_FFF8, "R2 key");
    rd(12'h02C, 32'h0FFF_FFFF, "R2 len");
    chk("R2 dst port", dst_addr_o, 32'h7FFF_FFF8);
    chk("R2 key port", key_addr_o, 32'h7FFF_FFF8);
    chk("R2 len port", src_len_o, 32'h0FFF_FFFF);
    wr(12'h020, 32'h1234_5671);
    chk("R2 src port", src_addr_o, 32'h1234_5671);

    // R3
    run_ok(32'h0000_0000, 3'd0, 1'b0, 1'b0, "R3 md5");
    run_ok(32'h0000_0020, 3'd1, 1'b0, 1'b0, "R3 sha1");
    run_ok(32'h0000_0040, 3'd2, 1'b0, 1'b0, "R3 sha224");
    run_ok(32'h0000_0050, 3'd3, 1'b0, 1'b0, "R3 sha256");
    run_ok(32'h0000_0060, 3'd5, 1'b0, 1'b0, "R3 sha512");
    run_ok(32'h0000_0460, 3'd4, 1'b0, 1'b0, "R3 sha384");
    run_ok(32'h0000_0860, 3'd3, 1'b0, 1'b0, "R3 512 family 256");

    // R4
    run_bad(32'h0000_0010, "R4 prim 001");
    run_bad(32'h0000_0030, "R4 prim 011");
    run_bad(32'h0000_0070, "R4 prim 111");
    run_bad(32'h0000_0C60, "R4 sub 011");
    run_bad(32'h0000_1020, "R4 sha1 nonzero sub");

    // R5
    run_ok(32'h0004_0050, 3'd3, 1'b1, 1'b0, "R5 sg");
    run_ok(32'h0000_0120, 3'd1, 1'b0, 1'b1, "R5 accumulate");
    run_ok(32'h0000_01A0, 3'd1, 1'b0, 1'b0, "R5 hmac key not acc");
    run_ok(32'h0000_00A0, 3'd1, 1'b0, 1'b0, "R5 hmac not acc");

    // R6
    run_bad(32'hFFFF_FFFF, "R6 cmd mask");

    // R7
    st_q.push_back({3'd2, 1'b0, 1'b0});
    st_tag_q.push_back("R7 first start");
    wr(12'h030, 32'h0000_0040);
    wr(12'h030, 32'h0000_0020);
    chk("R7 still busy", {31'b0, busy_o}, 32'h1);
    pulse_done();
    chk("R7 busy cleared", {31'b0, busy_o}, 32'h0);
    wr(12'h01C, 32'h200);
    run_ok(32'h0000_0020, 3'd1, 1'b0, 1'b0, "R7 start after done");

    // R8 without interrupt enable
    st_q.push_back({3'd0, 1'b0, 1'b0});
    st_tag_q.push_back("R8 start no ien");
    wr(12'h030, 32'h0000_0000);
    pulse_done();
    chk("R8 no irq", {31'b0, irq_o}, 32'h0);
    rd(12'h01C, 32'h0000_0200, "R8 status set without ien");
    // R9
    wr(12'h01C, 32'h0000_0000);
    rd(12'h01C, 32'h0000_0200, "R9 write 0 keeps");
    wr(12'h01C, 32'hFFFF_FFFF);
    rd(12'h01C, 32'h0000_0000, "R9 write 1 clears");

    // R8 with interrupt enable
    st_q.push_back({3'd3, 1'b0, 1'b0});
    st_tag_q.push_back("R8 start ien");
    wr(12'h030, 32'h0000_0250);
    chk("R8 irq low before done", {31'b0, irq_o}, 32'h0);
    pulse_done();
    chk("R8 irq raised", {31'b0, irq_o}, 32'h1);
    rd(12'h01C, 32'h0000_0200, "R8 status with ien");
    wr(12'h01C, 32'h0000_0000);
    chk("R9 irq kept on write 0", {31'b0, irq_o}, 32'h1);
    wr(12'h01C, 32'h0000_0200);
    chk("R9 irq lowered", {31'b0, irq_o}, 32'h0);

    // R10
    wr(12'h040, 32'hFFFF_FFFF);
    wr(12'h034, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h040, 32'h0, "R10 far read");
    rd(12'h034, 32'h0, "R10 past end read");
    rd(12'h000, 32'h0, "R10 hole read");
    rd(12'h020, 32'h1234_5671, "R10 src untouched");
    rd(12'h010, 32'hA5A5_5A5A, "R10 crypt untouched");
    chk("R10 no start", {31'b0, busy_o}, 32'h0);

    // R11
    pulse_done();
    chk("R11 irq idle", {31'b0, irq_o}, 32'h0);
    rd(12'h01C, 32'h0, "R11 status idle");

    repeat (4) @(negedge clk);
    chk("R3 R5 all starts seen", 32'(st_q.size()), 32'h0);
    chk("reads all compared", 32'(rd_q.size()), 32'h0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule